// File: doc/BRIEF.md
# Periodic Interrupt Timer

A 32-bit down-counting timer sits behind a small register port: a write strobe, a read strobe, a 5-bit byte address and 32-bit data in each direction. Software fills a load register and a compare register, chooses a prescale ratio, and then turns the timer on. The counter takes one step for every prescale+1 input ticks. When it reaches zero it either reloads from the load register or wraps to all ones. When a step lands on the compare value, the block raises a sticky flag, which can drive an interrupt line, and updates a compare output pin according to the selected pin mode.

The clock-source selector acts only as a gate on the single tick input. A setting of zero stops counting, and any other setting lets the tick through. A software reset clears the whole block from the register port.

Top module: `pit_timer`

## Requirements
- R1: After rst_n is held low at a clock edge, every register reads 0, and `irq` and `cmp_out` are low.
- R2: The control register (offset 0x00) stores bits 25:0 and reads them back, including bits 18 to 21, which have no effect. Bits 31:26 read as 0. The load register (0x08) and the compare register (0x0C) read back what was written.
- R3: A control write that takes enable (bit 0) from 0 to 1 starts the counter from the load value if bit 1 is 1. If bit 1 is 0, it starts from 0xFFFF_FFFF.
- R4: While enabled, the counter decrements once for every P+1 input ticks, where P is control bits 15:4.
- R5: With control bits 25:24 equal to 0, ticks are ignored and the count holds. Values 1 to 3 pass the tick input.
- R6: A step taken from 0 loads the load value when bit 3 (reload) is 1. When bit 3 is 0, it loads 0xFFFF_FFFF.
- R7: Status bit 0 (offset 0x04) is set when a step moves the counter onto the compare value. Writing 1 to it clears it, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R8: `irq` is high exactly while the status flag and control bit 2 are both 1.
- R9: Control bits 23:22 select the pin mode: 0 holds `cmp_out` low, 1 toggles it on a match, 2 clears it and 3 sets it.
- R10: When control bit 17 is 1, a write to the load register also places the written value in the counter at once.
- R11: Offset 0x10 reads the live count, and writes to it are ignored.
- R12: A control write with bit 16 set clears all registers, the count and the pin. Control then reads 0x0001_0000 for one cycle and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Counting tick, one per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is 0 when low |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Compare interrupt |
| cmp_out | output | 1 | Compare output pin |

## Verification
Properties checked on every cycle:
- the software-reset bit self-clears;
- a zero write leaves the flag alone;
- the count holds when no step or load event occurs;
- a nonzero count decrements by exactly one on a step;
- reload mode restores the load value at zero;
- the interrupt stays low with its enable off;
- the pin stays low when disconnected.

Some behaviour needs the bench's scripted sequences:
- where the enable-time start value comes from;
- the prescale ratio;
- the toggle, clear and set outcomes on real matches;
- the immediate-overwrite path;
- the exact cycle in which the software reset bit reads back.

// File: rtl/pit_pkg.sv
// Shared constants for the periodic interrupt timer.
// Assumes a 32-bit data path and a 5-bit byte address.
package pit_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int PRESC_W   = 12;
    localparam int CTRL_W    = 26;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CMP   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h10;

    localparam int CB_EN     = 0;
    localparam int CB_STSEL  = 1;
    localparam int CB_IRQEN  = 2;
    localparam int CB_RELOAD = 3;
    localparam int CB_PRE_LO = 4;
    localparam int CB_SWRST  = 16;
    localparam int CB_OVW    = 17;
    localparam int CB_OM_LO  = 22;
    localparam int CB_SRC_LO = 24;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_CLEAR  = 2'd2,
        PIN_SET    = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/pit_regs.sv
// Register file: control, status flag, load and compare, plus read mux.
// Produces one-cycle event strobes (start, overwrite, soft reset) decoded
// from the write port. Assumes one access per cycle.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int PW = PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count,
    input  logic          match,
    output logic [DW-1:0] rdata,
    output logic          en,
    output logic          irq_en,
    output logic          reload,
    output logic          src_on,
    output logic [PW-1:0] presc,
    output pin_mode_e     pin_mode,
    output logic [DW-1:0] load_val,
    output logic [DW-1:0] cmp_val,
    output logic          flag,
    output logic          swr_now,
    output logic          start_now,
    output logic [DW-1:0] start_val,
    output logic          ovw_now
);
    localparam logic [CTRL_W-1:0] SWR_ONLY = CTRL_W'(1) << CB_SWRST;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     load_q;
    logic [DW-1:0]     cmp_q;
    logic              flag_q;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;

    // Address decode of the write port.
    always_comb begin
        wr_ctrl = wr_en && (addr == OFF_CTRL);
        wr_stat = wr_en && (addr == OFF_STAT);
        wr_load = wr_en && (addr == OFF_LOAD);
        wr_cmp  = wr_en && (addr == OFF_CMP);
    end

    // Event strobes for the counter, prescaler and pin.
    always_comb begin
        swr_now   = wr_ctrl && wdata[CB_SWRST];
        start_now = wr_ctrl && wdata[CB_EN] && !ctrl_q[CB_EN] && !wdata[CB_SWRST];
        start_val = wdata[CB_STSEL] ? load_q : '1;
        ovw_now   = wr_load && ctrl_q[CB_OVW];
    end

    // Control register with a self-clearing soft-reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= '0;
        else if (swr_now)               ctrl_q <= SWR_ONLY;
        else if (wr_ctrl)               ctrl_q <= wdata[CTRL_W-1:0];
        else if (ctrl_q[CB_SWRST])      ctrl_q[CB_SWRST] <= 1'b0;
    end

    // Load and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_now) begin
            load_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_cmp)  cmp_q  <= wdata;
        end
    end

    // Sticky compare flag: a set wins over a same-cycle write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_now)           flag_q <= 1'b0;
        else if (match)                  flag_q <= 1'b1;
        else if (wr_stat && wdata[0])    flag_q <= 1'b0;
    end

    // Combinational read mux, zero when not reading.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                OFF_CTRL:  rdata = DW'(ctrl_q);
                OFF_STAT:  rdata = DW'(flag_q);
                OFF_LOAD:  rdata = load_q;
                OFF_CMP:   rdata = cmp_q;
                OFF_COUNT: rdata = count;
                default:   rdata = '0;
            endcase
        end
    end

    // Field breakout.
    always_comb begin
        en       = ctrl_q[CB_EN];
        irq_en   = ctrl_q[CB_IRQEN];
        reload   = ctrl_q[CB_RELOAD];
        src_on   = |ctrl_q[CB_SRC_LO +: 2];
        presc    = ctrl_q[CB_PRE_LO +: PW];
        pin_mode = pin_mode_e'(ctrl_q[CB_OM_LO +: 2]);
        load_val = load_q;
        cmp_val  = cmp_q;
        flag     = flag_q;
    end

    // R12
    swr_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_SWRST] && !wr_ctrl) |=> !ctrl_q[CB_SWRST]);

    // R7
    flag_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_stat && wdata[0]) && !swr_now) |=> flag_q);
endmodule

// File: rtl/pit_prescaler.sv
// Tick divider: emits one step per PRESC+1 qualified ticks.
// Assumes restart is a one-cycle strobe; a lowered ratio takes effect at
// the next qualified tick.
module pit_prescaler #(
    parameter int PW = pit_pkg::PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick_ok,
    input  logic [PW-1:0] presc,
    output logic          step
);
    logic [PW-1:0] pcnt;

    // Step when the tick count has reached the ratio.
    always_comb step = tick_ok && !restart && (pcnt >= presc);

    // Count qualified ticks, return to zero on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) pcnt <= '0;
        else if (step)         pcnt <= '0;
        else if (tick_ok)      pcnt <= pcnt + 1'b1;
    end

    // R4
    pcnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step || restart) |=> (pcnt == '0));
endmodule

// File: rtl/pit_counter.sv
// Down counter with start, overwrite, reload/wrap and compare detection.
// Assumes event strobes are single-cycle and mutually exclusive with writes.
module pit_counter #(
    parameter int DW = pit_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          swr_now,
    input  logic          start_now,
    input  logic [DW-1:0] start_val,
    input  logic          ovw_now,
    input  logic [DW-1:0] ovw_val,
    input  logic          reload,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] cmp_val,
    output logic [DW-1:0] count,
    output logic          match
);
    logic [DW-1:0] next_val;
    logic          load_evt;

    // Value after one step: decrement, or reload/wrap at zero.
    always_comb begin
        next_val = (count == '0) ? (reload ? load_val : '1) : count - 1'b1;
        load_evt = swr_now || start_now || ovw_now;
        match    = step && !load_evt && (next_val == cmp_val);
    end

    // Count register with load events ahead of stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_now) count <= '0;
        else if (start_now)    count <= start_val;
        else if (ovw_now)      count <= ovw_val;
        else if (step)         count <= next_val;
    end

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_evt) |=> $stable(count));

    // R4
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_evt && count != '0) |=> (count == $past(count) - 1'b1));

    // R6
    count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_evt && count == '0 && reload) |=> (count == $past(load_val)));
endmodule

// File: rtl/pit_outpin.sv
// Compare output pin driven by the selected mode on each match.
// Assumes the pin is forced low whenever the mode is disconnected.
module pit_outpin
    import pit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      swr_now,
    input  logic      match,
    input  pin_mode_e mode,
    output logic      pin
);
    logic pin_q;

    // Pin state update on compare events.
    always_ff @(posedge clk) begin
        if (!rst_n || swr_now)   pin_q <= 1'b0;
        else if (mode == PIN_OFF) pin_q <= 1'b0;
        else if (match) begin
            unique case (mode)
                PIN_TOGGLE: pin_q <= !pin_q;
                PIN_CLEAR:  pin_q <= 1'b0;
                PIN_SET:    pin_q <= 1'b1;
                default:    pin_q <= 1'b0;
            endcase
        end
    end

    // Disconnected mode gates the pin low at once.
    always_comb pin = pin_q && (mode != PIN_OFF);

    // R9
    pin_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_OFF) |-> !pin);
endmodule

// File: rtl/pit_timer.sv
// Top of the periodic interrupt timer: wires registers, prescaler,
// counter and output pin. Assumes tick_in is synchronous to clk.
module pit_timer
    import pit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int PW = PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq,
    output logic          cmp_out
);
    logic          en, irq_en, reload, src_on, flag;
    logic          swr_now, start_now, ovw_now, step, match, tick_ok;
    logic [PW-1:0] presc;
    pin_mode_e     pin_mode;
    logic [DW-1:0] load_val, cmp_val, start_val, count;

    pit_regs #(.DW(DW), .AW(AW), .PW(PW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count(count), .match(match),
        .rdata(rdata), .en(en), .irq_en(irq_en), .reload(reload),
        .src_on(src_on), .presc(presc), .pin_mode(pin_mode),
        .load_val(load_val), .cmp_val(cmp_val), .flag(flag),
        .swr_now(swr_now), .start_now(start_now), .start_val(start_val),
        .ovw_now(ovw_now)
    );

    // Tick qualified by enable and a non-off clock source.
    always_comb tick_ok = tick_in && en && src_on;

    pit_prescaler #(.PW(PW)) presc_i (
        .clk(clk), .rst_n(rst_n), .restart(swr_now || start_now),
        .tick_ok(tick_ok), .presc(presc), .step(step)
    );

    pit_counter #(.DW(DW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .step(step), .swr_now(swr_now),
        .start_now(start_now), .start_val(start_val), .ovw_now(ovw_now),
        .ovw_val(wdata), .reload(reload), .load_val(load_val),
        .cmp_val(cmp_val), .count(count), .match(match)
    );

    pit_outpin pin_i (
        .clk(clk), .rst_n(rst_n), .swr_now(swr_now), .match(match),
        .mode(pin_mode), .pin(cmp_out)
    );

    // Interrupt is the flag masked by its enable.
    always_comb irq = flag && irq_en;

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R5
    src_off_nostep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_on |-> !step);
endmodule

// File: tb/pit_timer_tb.sv
// Bench: a vector table walked by one loop, then directed reset tests.
module pit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, cmp_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = !clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .cmp_out(cmp_out)
    );

    localparam logic [1:0] WR = 2'd0, RD = 2'd1, TK = 2'd2, PN = 2'd3;
    // entry = {req[3:0], op[1:0], addr[4:0], data[31:0]}; PN data = {irq,cmp_out}
    localparam int NV = 64;
    localparam logic [42:0] VEC [NV] = '{
        {4'd2,  WR, 5'h08, 32'h0000_0005},  // R2
        {4'd2,  WR, 5'h0C, 32'h0000_0003},
        {4'd2,  RD, 5'h08, 32'h0000_0005},
        {4'd2,  RD, 5'h0C, 32'h0000_0003},
        {4'd3,  WR, 5'h00, 32'h02C0_000F},  // R3 start from load
        {4'd3,  RD, 5'h10, 32'h0000_0005},
        {4'd4,  TK, 5'h00, 32'd2},          // R4
        {4'd4,  RD, 5'h10, 32'h0000_0003},
        {4'd7,  RD, 5'h04, 32'h0000_0001},  // R7 set on match
        {4'd8,  PN, 5'h00, 32'd3},          // R8 / R9 set mode
        {4'd4,  TK, 5'h00, 32'd3},
        {4'd4,  RD, 5'h10, 32'h0000_0000},
        {4'd6,  TK, 5'h00, 32'd1},          // R6 reload
        {4'd6,  RD, 5'h10, 32'h0000_0005},
        {4'd7,  WR, 5'h04, 32'h0000_0000},  // R7 zero write
        {4'd7,  RD, 5'h04, 32'h0000_0001},
        {4'd7,  WR, 5'h04, 32'h0000_0001},
        {4'd7,  RD, 5'h04, 32'h0000_0000},
        {4'd8,  PN, 5'h00, 32'd1},          // R8 irq drops
        {4'd4,  WR, 5'h00, 32'h02C0_002F},  // R4 prescale 2
        {4'd4,  TK, 5'h00, 32'd3},
        {4'd4,  RD, 5'h10, 32'h0000_0004},
        {4'd4,  TK, 5'h00, 32'd2},
        {4'd4,  RD, 5'h10, 32'h0000_0004},
        {4'd4,  TK, 5'h00, 32'd1},
        {4'd4,  RD, 5'h10, 32'h0000_0003},
        {4'd5,  WR, 5'h00, 32'h00C0_002F},  // R5 source off
        {4'd5,  TK, 5'h00, 32'd6},
        {4'd5,  RD, 5'h10, 32'h0000_0003},
        {4'd7,  WR, 5'h04, 32'h0000_0001},
        {4'd6,  WR, 5'h0C, 32'hFFFF_FFFF},
        {4'd6,  WR, 5'h00, 32'h0240_0007},  // R6 free run, toggle
        {4'd6,  TK, 5'h00, 32'd3},
        {4'd6,  RD, 5'h10, 32'h0000_0000},
        {4'd6,  TK, 5'h00, 32'd1},
        {4'd6,  RD, 5'h10, 32'hFFFF_FFFF},  // R6 wrap
        {4'd9,  PN, 5'h00, 32'd2},          // R9 toggle 1->0
        {4'd10, WR, 5'h00, 32'h0262_0007},  // R10
        {4'd10, WR, 5'h08, 32'h0000_0010},
        {4'd10, RD, 5'h10, 32'h0000_0010},
        {4'd3,  WR, 5'h00, 32'h0000_0000},
        {4'd9,  PN, 5'h00, 32'd0},
        {4'd3,  WR, 5'h00, 32'h0200_0001},  // R3 start all ones
        {4'd3,  RD, 5'h10, 32'hFFFF_FFFF},
        {4'd11, TK, 5'h00, 32'd1},
        {4'd11, RD, 5'h10, 32'hFFFF_FFFE},  // R11 live
        {4'd11, WR, 5'h10, 32'h0000_0055},
        {4'd11, RD, 5'h10, 32'hFFFF_FFFE},  // R11 write ignored
        {4'd9,  WR, 5'h00, 32'h02C0_0001},
        {4'd9,  WR, 5'h0C, 32'hFFFF_FFFD},
        {4'd9,  TK, 5'h00, 32'd1},
        {4'd9,  PN, 5'h00, 32'd1},          // R9 set
        {4'd9,  WR, 5'h00, 32'h0280_0001},
        {4'd9,  WR, 5'h0C, 32'hFFFF_FFFC},
        {4'd9,  TK, 5'h00, 32'd1},
        {4'd9,  PN, 5'h00, 32'd0},          // R9 clear
        {4'd9,  WR, 5'h00, 32'h02C0_0001},
        {4'd9,  WR, 5'h0C, 32'hFFFF_FFFB},
        {4'd9,  TK, 5'h00, 32'd1},
        {4'd9,  PN, 5'h00, 32'd1},
        {4'd9,  WR, 5'h00, 32'h0200_0001},
        {4'd9,  PN, 5'h00, 32'd0},          // R9 disconnected
        {4'd2,  WR, 5'h00, 32'h023C_0001},
        {4'd2,  RD, 5'h00, 32'h023C_0001}   // R2 stored bits
    };

    function automatic void check(int req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endfunction

    task automatic do_wr(logic [4:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(int req, logic [4:0] a, logic [31:0] exp);
        rd_en = 1'b1; addr = a;
        #2;
        check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_tk(int n);
        for (int i = 0; i < n; i++) begin
            tick_in = 1'b1;
            @(negedge clk);
            tick_in = 1'b0;
        end
    endtask

    task automatic do_pin(int req, logic [1:0] exp);
        #2;
        check(req, {30'd0, irq, cmp_out}, {30'd0, exp});
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        do_pin(1, 2'b00);
        do_rd(1, 5'h00, 32'h0);
        do_rd(1, 5'h04, 32'h0);
        do_rd(1, 5'h08, 32'h0);
        do_rd(1, 5'h0C, 32'h0);
        do_rd(1, 5'h10, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [42:0] e;
            e = VEC[v];
            unique case (e[38:37])
                WR: do_wr(e[36:32], e[31:0]);
                RD: do_rd(int'(e[42:39]), e[36:32], e[31:0]);
                TK: do_tk(int'(e[31:0]));
                PN: do_pin(int'(e[42:39]), e[1:0]);
                default: ;
            endcase
        end

        // R12 software reset: bit visible one cycle, everything cleared
        do_wr(5'h00, 32'h0001_0000);
        do_rd(12, 5'h00, 32'h0001_0000);
        do_rd(12, 5'h00, 32'h0);
        do_rd(12, 5'h08, 32'h0);
        do_rd(12, 5'h0C, 32'h0);
        do_rd(12, 5'h10, 32'h0);
        do_rd(12, 5'h04, 32'h0);
        do_pin(12, 2'b00);

        // R1 reset pin mid-run
        do_wr(5'h08, 32'h0000_0007);
        do_wr(5'h00, 32'h02C0_0007);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_rd(1, 5'h08, 32'h0);
        do_rd(1, 5'h00, 32'h0);
        do_rd(1, 5'h10, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule